// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Writeback Slot Reservation

This block is the scheduling window of a single-issue core that may issue out of program order. Renamed instructions arrive in program order, at most one per cycle, and wait in a 16-entry window. Each entry records which execution unit it needs, two source tags with ready flags, and a destination tag. Every cycle the block picks at most one instruction whose operands are available and sends it to its unit.

The register file has a single write port. Units differ in latency, so a fast operation issued later can finish in the same cycle as a slow operation issued earlier. To prevent this, the block keeps a shift register of reserved future writeback cycles. An instruction is eligible only when the cycle its result would be written is still free.

The block also produces the writeback broadcast. In the cycle a result is written, its tag appears on the broadcast output. Waiting entries that match that tag are woken one cycle earlier, so a dependent instruction can issue in the same cycle its producer's result is broadcast. This models full bypassing.

Top module: `ooo_issue_queue`

## Requirements
- R1: After reset the window is empty, `full` is low, and neither `iss_valid` nor `wb_valid` is asserted.
- R2: The window holds 16 entries. `full` is high exactly while 16 are held. A request on the enqueue port while `full` is high is dropped. An issue from a full window drops `full` in the next cycle.
- R3: When several entries are eligible in the same cycle, the one that entered first is issued.
- R4: Unit codes are 0 for ALU/branch, 1 for load, 2 for multiply and 3 for store. For codes 0, 1 and 2, `wb_valid` with `wb_tag` equal to the destination is asserted 1, 2 and 4 cycles after `iss_valid` shows the instruction.
- R5: An instruction whose writeback cycle is already reserved is held, even when its operands are ready. It issues in a later cycle whose slot is free. At most one broadcast occurs per cycle.
- R6: An entry waiting on a tag can show `iss_valid` in the same cycle that tag appears on `wb_valid`/`wb_tag`.
- R7: An instruction enqueued with both sources ready shows `iss_valid` two cycles after the enqueue cycle, provided no older entry is eligible and its writeback slot is free.
- R8: A store (code 3) reserves no writeback slot and causes no broadcast. It may issue ahead of an older entry that is held by a slot conflict.
- R9: On enqueue, a source counts as ready if its ready flag is set, if its tag is on `wb_tag` in that cycle, or if its tag is to be broadcast in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue request |
| enq_fu | input | 2 | Unit code of the incoming instruction |
| enq_src1 | input | TAG_W | First source tag |
| enq_rdy1 | input | 1 | First source already available |
| enq_src2 | input | TAG_W | Second source tag |
| enq_rdy2 | input | 1 | Second source already available |
| enq_dst | input | TAG_W | Destination tag |
| full | output | 1 | Window holds DEPTH entries |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_fu | output | 2 | Unit code of the issued instruction |
| iss_src1 | output | TAG_W | First source tag of the issued instruction |
| iss_src2 | output | TAG_W | Second source tag of the issued instruction |
| iss_dst | output | TAG_W | Destination tag of the issued instruction |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_tag | output | TAG_W | Tag of the result being written back |

## Verification
Isolated instructions of each unit type, with idle gaps between them, separate latency errors from selection errors. Short dependent chains show whether wakeup lines up with the broadcast.

A multiply followed by ready load and ALU operations forces writeback collisions. Adding a younger store to that mix shows whether stores skip the reservation. A long multiply chain fills the window, and a ready instruction offered only while `full` is high would issue at once if it were wrongly accepted.

Sources enqueued as not ready while their producer is about to be broadcast test the enqueue-time capture. Random traffic then checks every cycle against a bench model, with ready flags drawn from the model's own record of tags still in flight.

// File: rtl/iq_pkg.sv
package iq_pkg;
  typedef enum logic [1:0] {
    FU_ALU   = 2'd0,
    FU_LOAD  = 2'd1,
    FU_MUL   = 2'd2,
    FU_STORE = 2'd3
  } fu_e;
endpackage

// File: rtl/iq_oldest_pick.sv
// Fixed-priority picker: lowest index (oldest entry) wins.
module iq_oldest_pick #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx
);
  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/iq_wb_sched.sv
// Writeback slot reservation: position k holds the result written k cycles from now.
module iq_wb_sched #(
  parameter int SLOTS = 5,
  parameter int TAG_W = 5,
  localparam int LW = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_en,
  input  logic [LW-1:0]    alloc_lat,
  input  logic [TAG_W-1:0] alloc_tag,
  output logic [SLOTS:0]   busy,
  output logic             wake_valid,
  output logic [TAG_W-1:0] wake_tag,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag
);
  logic [SLOTS:0]   v;
  logic [TAG_W-1:0] t [SLOTS+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      v <= '0;
      for (int k = 0; k <= SLOTS; k++) t[k] <= '0;
    end else begin
      for (int k = 0; k < SLOTS; k++) begin
        v[k] <= v[k+1];
        t[k] <= t[k+1];
      end
      v[SLOTS] <= 1'b0;
      t[SLOTS] <= '0;
      if (alloc_en) begin
        v[alloc_lat] <= 1'b1;
        t[alloc_lat] <= alloc_tag;
      end
    end
  end

  assign busy       = v;
  assign wake_valid = v[1];
  assign wake_tag   = t[1];
  assign wb_valid   = v[0];
  assign wb_tag     = t[0];
endmodule

// File: rtl/ooo_issue_queue.sv
module ooo_issue_queue
  import iq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int TAG_W    = 5,
  parameter int LAT_ALU  = 1,
  parameter int LAT_LOAD = 2,
  parameter int LAT_MUL  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_valid,
  input  logic [1:0]       enq_fu,
  input  logic [TAG_W-1:0] enq_src1,
  input  logic             enq_rdy1,
  input  logic [TAG_W-1:0] enq_src2,
  input  logic             enq_rdy2,
  input  logic [TAG_W-1:0] enq_dst,
  output logic             full,
  output logic             iss_valid,
  output logic [1:0]       iss_fu,
  output logic [TAG_W-1:0] iss_src1,
  output logic [TAG_W-1:0] iss_src2,
  output logic [TAG_W-1:0] iss_dst,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag
);
  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int MAX_LAT = (LAT_MUL > LAT_LOAD) ? ((LAT_MUL > LAT_ALU) ? LAT_MUL : LAT_ALU)
                                                : ((LAT_LOAD > LAT_ALU) ? LAT_LOAD : LAT_ALU);
  localparam int SLOTS   = MAX_LAT + 1;
  localparam int LW      = $clog2(SLOTS + 1);

  function automatic logic [LW-1:0] lat_of(fu_e f);
    case (f)
      FU_LOAD: return LW'(LAT_LOAD);
      FU_MUL:  return LW'(LAT_MUL);
      default: return LW'(LAT_ALU);
    endcase
  endfunction

  // Window storage, kept compacted: index 0 is the oldest entry.
  logic [DEPTH-1:0] e_v, e_r1, e_r2;
  fu_e              e_fu  [DEPTH];
  logic [TAG_W-1:0] e_s1  [DEPTH];
  logic [TAG_W-1:0] e_s2  [DEPTH];
  logic [TAG_W-1:0] e_dst [DEPTH];
  logic [CNT_W-1:0] count;

  logic [DEPTH-1:0] n_v, n_r1, n_r2;
  fu_e              n_fu  [DEPTH];
  logic [TAG_W-1:0] n_s1  [DEPTH];
  logic [TAG_W-1:0] n_s2  [DEPTH];
  logic [TAG_W-1:0] n_dst [DEPTH];
  logic [CNT_W-1:0] n_count;

  logic [SLOTS:0]   slot_busy;
  logic             wake_valid;
  logic [TAG_W-1:0] wake_tag;
  logic [DEPTH-1:0] rdy1_w, rdy2_w, slot_ok, req;
  logic             gnt_valid;
  logic [IDX_W-1:0] gnt_idx;
  logic             enq_ok, alloc_en;
  logic             in_r1, in_r2;

  // Wakeup and eligibility per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [LW-1:0] lat_i;
    assign lat_i      = lat_of(e_fu[i]);
    assign rdy1_w[i]  = e_r1[i] | (wake_valid && (wake_tag == e_s1[i]));
    assign rdy2_w[i]  = e_r2[i] | (wake_valid && (wake_tag == e_s2[i]));
    assign slot_ok[i] = (e_fu[i] == FU_STORE) || !slot_busy[int'(lat_i) + 1];
    assign req[i]     = e_v[i] & rdy1_w[i] & rdy2_w[i] & slot_ok[i];
  end

  iq_oldest_pick #(.N(DEPTH)) u_pick (
    .req       (req),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  assign alloc_en = gnt_valid && (e_fu[gnt_idx] != FU_STORE);

  iq_wb_sched #(.SLOTS(SLOTS), .TAG_W(TAG_W)) u_wb (
    .clk        (clk),
    .rst        (rst),
    .alloc_en   (alloc_en),
    .alloc_lat  (lat_of(e_fu[gnt_idx])),
    .alloc_tag  (e_dst[gnt_idx]),
    .busy       (slot_busy),
    .wake_valid (wake_valid),
    .wake_tag   (wake_tag),
    .wb_valid   (wb_valid),
    .wb_tag     (wb_tag)
  );

  assign enq_ok = enq_valid && !full;
  assign in_r1  = enq_rdy1 | (wake_valid && (wake_tag == enq_src1)) | (wb_valid && (wb_tag == enq_src1));
  assign in_r2  = enq_rdy2 | (wake_valid && (wake_tag == enq_src2)) | (wb_valid && (wb_tag == enq_src2));

  // Next window: close the gap left by the issued entry, append the new one
  always_comb begin
    int ins;
    ins = int'(count) - int'(gnt_valid);
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      src = i + ((gnt_valid && (i >= int'(gnt_idx))) ? 1 : 0);
      if (src < DEPTH) begin
        n_v[i]   = e_v[src];
        n_r1[i]  = rdy1_w[src];
        n_r2[i]  = rdy2_w[src];
        n_fu[i]  = e_fu[src];
        n_s1[i]  = e_s1[src];
        n_s2[i]  = e_s2[src];
        n_dst[i] = e_dst[src];
      end else begin
        n_v[i]   = 1'b0;
        n_r1[i]  = 1'b0;
        n_r2[i]  = 1'b0;
        n_fu[i]  = FU_ALU;
        n_s1[i]  = '0;
        n_s2[i]  = '0;
        n_dst[i] = '0;
      end
      if (enq_ok && (i == ins)) begin
        n_v[i]   = 1'b1;
        n_r1[i]  = in_r1;
        n_r2[i]  = in_r2;
        n_fu[i]  = fu_e'(enq_fu);
        n_s1[i]  = enq_src1;
        n_s2[i]  = enq_src2;
        n_dst[i] = enq_dst;
      end
    end
    n_count = CNT_W'(int'(count) - int'(gnt_valid) + int'(enq_ok));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      e_v       <= '0;
      e_r1      <= '0;
      e_r2      <= '0;
      count     <= '0;
      full      <= 1'b0;
      iss_valid <= 1'b0;
      iss_fu    <= '0;
      iss_src1  <= '0;
      iss_src2  <= '0;
      iss_dst   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_fu[i]  <= FU_ALU;
        e_s1[i]  <= '0;
        e_s2[i]  <= '0;
        e_dst[i] <= '0;
      end
    end else begin
      e_v   <= n_v;
      e_r1  <= n_r1;
      e_r2  <= n_r2;
      e_fu  <= n_fu;
      e_s1  <= n_s1;
      e_s2  <= n_s2;
      e_dst <= n_dst;
      count <= n_count;
      full  <= (int'(n_count) == DEPTH);
      iss_valid <= gnt_valid;
      if (gnt_valid) begin
        iss_fu   <= e_fu[gnt_idx];
        iss_src1 <= e_s1[gnt_idx];
        iss_src2 <= e_s2[gnt_idx];
        iss_dst  <= e_dst[gnt_idx];
      end
    end
  end
endmodule

// File: rtl/iq_checks.sv
// Properties assume the default unit latencies (1, 2, 4).
module iq_checks #(
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             full,
  input logic             iss_valid,
  input logic [1:0]       iss_fu,
  input logic [TAG_W-1:0] iss_dst,
  input logic             wb_valid,
  input logic [TAG_W-1:0] wb_tag
);
  // R4
  alu_wb_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_fu == 2'd0) |=> (wb_valid && wb_tag == $past(iss_dst)));

  // R4
  load_wb_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_fu == 2'd1) |=> ##1 (wb_valid && wb_tag == $past(iss_dst, 2)));

  // R4
  mul_wb_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_fu == 2'd2) |=> ##3 (wb_valid && wb_tag == $past(iss_dst, 4)));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    full |=> (full != iss_valid));
endmodule

bind ooo_issue_queue iq_checks #(.TAG_W(TAG_W)) u_iq_checks (
  .clk       (clk),
  .rst       (rst),
  .full      (full),
  .iss_valid (iss_valid),
  .iss_fu    (iss_fu),
  .iss_dst   (iss_dst),
  .wb_valid  (wb_valid),
  .wb_tag    (wb_tag)
);

// File: tb/test_ooo_issue_queue.sv
`timescale 1ns/1ps
module test_ooo_issue_queue;
  localparam int DEPTH = 16;
  localparam int TW    = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enq_valid = 1'b0;
  logic [1:0] enq_fu = '0;
  logic [TW-1:0] enq_src1 = '0, enq_src2 = '0, enq_dst = '0;
  logic enq_rdy1 = 1'b0, enq_rdy2 = 1'b0;
  logic full, iss_valid, wb_valid;
  logic [1:0] iss_fu;
  logic [TW-1:0] iss_src1, iss_src2, iss_dst, wb_tag;

  always #2 clk = ~clk;

  ooo_issue_queue i_ooo_issue_queue (
    .clk(clk), .rst(rst),
    .enq_valid(enq_valid), .enq_fu(enq_fu),
    .enq_src1(enq_src1), .enq_rdy1(enq_rdy1),
    .enq_src2(enq_src2), .enq_rdy2(enq_rdy2),
    .enq_dst(enq_dst), .full(full),
    .iss_valid(iss_valid), .iss_fu(iss_fu),
    .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_dst(iss_dst),
    .wb_valid(wb_valid), .wb_tag(wb_tag)
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // Bench model of the requirements
  int            m_cnt;
  logic [1:0]    q_fu [DEPTH];
  logic [TW-1:0] q_s1 [DEPTH];
  logic [TW-1:0] q_s2 [DEPTH];
  logic [TW-1:0] q_d  [DEPTH];
  bit            q_r1 [DEPTH];
  bit            q_r2 [DEPTH];
  bit            sv [6];
  logic [TW-1:0] st [6];
  bit            m_iv, m_full;
  logic [1:0]    m_fu;
  logic [TW-1:0] m_s1, m_s2, m_d;

  function automatic int lat(logic [1:0] f);
    case (f)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit pend(logic [TW-1:0] tg);
    for (int i = 0; i < m_cnt; i++)
      if (q_fu[i] != 2'd3 && q_d[i] == tg) return 1'b1;
    for (int k = 1; k < 6; k++)
      if (sv[k] && st[k] == tg) return 1'b1;
    return 1'b0;
  endfunction

  task automatic m_reset();
    m_cnt = 0; m_iv = 0; m_full = 0;
    m_fu = '0; m_s1 = '0; m_s2 = '0; m_d = '0;
    for (int k = 0; k < 6; k++) begin sv[k] = 0; st[k] = '0; end
  endtask

  task automatic m_step();
    bit wv, bv, acc;
    logic [TW-1:0] wt, bt;
    int pick;
    wv = sv[1]; wt = st[1]; bv = sv[0]; bt = st[0];
    acc = enq_valid && !m_full;
    pick = -1;
    for (int i = 0; i < m_cnt; i++) begin
      if (wv && wt == q_s1[i]) q_r1[i] = 1;
      if (wv && wt == q_s2[i]) q_r2[i] = 1;
      if (pick < 0 && q_r1[i] && q_r2[i] &&
          (q_fu[i] == 2'd3 || !sv[lat(q_fu[i]) + 1])) pick = i;
    end
    for (int k = 0; k < 5; k++) begin sv[k] = sv[k+1]; st[k] = st[k+1]; end
    sv[5] = 0;
    m_iv = (pick >= 0);
    if (pick >= 0) begin
      m_fu = q_fu[pick]; m_s1 = q_s1[pick]; m_s2 = q_s2[pick]; m_d = q_d[pick];
      if (m_fu != 2'd3) begin sv[lat(m_fu)] = 1; st[lat(m_fu)] = m_d; end
      for (int i = pick; i < m_cnt - 1; i++) begin
        q_fu[i] = q_fu[i+1]; q_s1[i] = q_s1[i+1]; q_s2[i] = q_s2[i+1];
        q_d[i] = q_d[i+1]; q_r1[i] = q_r1[i+1]; q_r2[i] = q_r2[i+1];
      end
      m_cnt--;
    end
    if (acc) begin
      q_fu[m_cnt] = enq_fu; q_s1[m_cnt] = enq_src1; q_s2[m_cnt] = enq_src2;
      q_d[m_cnt] = enq_dst;
      q_r1[m_cnt] = enq_rdy1 || (wv && wt == enq_src1) || (bv && bt == enq_src1);
      q_r2[m_cnt] = enq_rdy2 || (wv && wt == enq_src2) || (bv && bt == enq_src2);
      m_cnt++;
    end
    m_full = (m_cnt == DEPTH);
  endtask

  task automatic cmp();
    bit bad;
    n_chk++;
    bad = (iss_valid !== m_iv) || (wb_valid !== sv[0]) || (full !== m_full);
    if (m_iv && (iss_fu !== m_fu || iss_src1 !== m_s1 || iss_src2 !== m_s2 || iss_dst !== m_d)) bad = 1;
    if (sv[0] && wb_tag !== st[0]) bad = 1;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got iss=%0d fu=%0d s=%0d,%0d d=%0d wb=%0d/%0d full=%0d; expected iss=%0d fu=%0d s=%0d,%0d d=%0d wb=%0d/%0d full=%0d",
               cur_req, iss_valid, iss_fu, iss_src1, iss_src2, iss_dst, wb_valid, wb_tag, full,
               m_iv, m_fu, m_s1, m_s2, m_d, sv[0], st[0], m_full);
    end
  endtask

  task automatic cyc(input bit v, input logic [1:0] f, input logic [TW-1:0] a, input bit ra,
                     input logic [TW-1:0] b, input bit rb, input logic [TW-1:0] d);
    cmp();
    enq_valid = v; enq_fu = f; enq_src1 = a; enq_rdy1 = ra;
    enq_src2 = b; enq_rdy2 = rb; enq_dst = d;
    m_step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) cyc(0, 2'd0, '0, 1, '0, 1, '0);
  endtask

  task automatic do_reset();
    rst = 1; enq_valid = 0;
    m_reset();
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    cmp();   // R1 reset state
    rst = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [TW-1:0] hist [4];
    logic [TW-1:0] prev, a, b;
    int k;
    void'($urandom(32'd4711));
    @(negedge clk);

    // R4 and R7: isolated instructions of each unit
    do_reset();
    cur_req = "R4/R7";
    cyc(1, 2'd0, 5'd1, 1, 5'd2, 1, 5'd3); idle(4);
    cyc(1, 2'd1, 5'd1, 1, 5'd2, 1, 5'd4); idle(5);
    cyc(1, 2'd2, 5'd1, 1, 5'd2, 1, 5'd5); idle(7);
    cyc(1, 2'd3, 5'd1, 1, 5'd2, 1, 5'd6); idle(5);

    // R6: dependent chain issues alongside producer broadcast
    do_reset();
    cur_req = "R6";
    cyc(1, 2'd2, 5'd1, 1, 5'd2, 1, 5'd7);
    cyc(1, 2'd0, 5'd7, 0, 5'd2, 1, 5'd8);
    cyc(1, 2'd0, 5'd8, 0, 5'd7, 0, 5'd9);
    cyc(1, 2'd1, 5'd9, 0, 5'd2, 1, 5'd10);
    cyc(1, 2'd0, 5'd10, 0, 5'd2, 1, 5'd11);
    idle(14);

    // R5: writeback collisions between ready instructions
    do_reset();
    cur_req = "R5";
    cyc(1, 2'd2, 5'd0, 1, 5'd0, 1, 5'd1);
    cyc(1, 2'd1, 5'd0, 1, 5'd0, 1, 5'd2);
    cyc(1, 2'd0, 5'd0, 1, 5'd0, 1, 5'd3);
    cyc(1, 2'd0, 5'd0, 1, 5'd0, 1, 5'd4);
    cyc(1, 2'd1, 5'd0, 1, 5'd0, 1, 5'd5);
    cyc(1, 2'd0, 5'd0, 1, 5'd0, 1, 5'd6);
    idle(12);

    // R3: several entries woken by the same tag
    do_reset();
    cur_req = "R3";
    cyc(1, 2'd2, 5'd0, 1, 5'd0, 1, 5'd12);
    cyc(1, 2'd0, 5'd12, 0, 5'd0, 1, 5'd13);
    cyc(1, 2'd3, 5'd12, 0, 5'd0, 1, 5'd0);
    cyc(1, 2'd0, 5'd0, 1, 5'd12, 0, 5'd14);
    cyc(1, 2'd1, 5'd12, 0, 5'd12, 0, 5'd15);
    idle(12);

    // R8: younger store passes an older slot-blocked ALU op
    do_reset();
    cur_req = "R8";
    cyc(1, 2'd2, 5'd0, 1, 5'd0, 1, 5'd1);
    cyc(1, 2'd1, 5'd0, 1, 5'd0, 1, 5'd2);
    cyc(1, 2'd0, 5'd0, 1, 5'd0, 1, 5'd3);
    cyc(1, 2'd3, 5'd0, 1, 5'd0, 1, 5'd4);
    cyc(1, 2'd3, 5'd0, 1, 5'd0, 1, 5'd5);
    idle(12);

    // R9: sources not flagged ready while producer is being broadcast
    do_reset();
    cur_req = "R9";
    cyc(1, 2'd2, 5'd0, 1, 5'd0, 1, 5'd20);
    idle(2);
    for (int j = 0; j < 6; j++) cyc(1, 2'd0, 5'd20, 0, 5'd0, 1, 5'(21 + j));
    idle(12);

    // R2: fill with a multiply chain; offer a ready op only while full
    do_reset();
    cur_req = "R2";
    prev = 5'd1;
    cyc(1, 2'd2, 5'd0, 1, 5'd0, 1, prev);
    k = 2;
    for (int j = 0; j < 80; j++) begin
      if (m_full) cyc(1, 2'd0, 5'd0, 1, 5'd0, 1, 5'd30);
      else if (k <= 28) begin
        cyc(1, 2'd2, prev, !pend(prev), 5'd0, 1, 5'(k));
        prev = 5'(k);
        k++;
      end else idle(1);
    end
    idle(130);

    // Random traffic, R3 ordering against the model
    do_reset();
    cur_req = "R3";
    for (int j = 0; j < 4; j++) hist[j] = '0;
    k = 0;
    for (int j = 0; j < 3000; j++) begin
      if ($urandom_range(0, 9) < 7) begin
        logic [1:0] f;
        f = 2'($urandom_range(0, 3));
        a = ($urandom_range(0, 1) != 0) ? hist[$urandom_range(0, 3)] : 5'($urandom_range(0, 31));
        b = ($urandom_range(0, 1) != 0) ? hist[$urandom_range(0, 3)] : 5'($urandom_range(0, 31));
        k = (k + 1) % 32;
        cyc(1, f, a, !pend(a), b, !pend(b), 5'(k));
        if (f != 2'd3) begin
          hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = 5'(k);
        end
      end else idle(1);
    end
    idle(150);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule